// File: doc/BRIEF.md
# Serial Gain-Word Receiver and Decoder

This block takes a gain setting from a three-wire serial link (an active-low enable, a data line and a serial clock) and turns it into digital attenuation indices for a programmable line driver. All three serial lines are brought into the core clock domain through a short synchronizer, and their edges are found there. While the enable is low, each rising serial-clock edge shifts one data bit into a seven-bit register, most significant bit first. A word is eight bits long, so the first bit sent falls off the top by the eighth clock and never matters. A rising enable edge commits the register to a held gain latch and stops any further shifting.

The latched code is split into a coarse attenuation index and a fine vernier index. The coarse index saturates at eight, so codes above the valid range of 0 to 71 give a sawtooth on the effective gain step. Two asynchronous active-low pins, power-down and sleep, choose the power mode together with a flag that records whether any word has been committed since reset. Transmit is enabled only when all three allow it. There is no data stream here: a word is committed by the enable edge alone, nothing is buffered and there is no back-pressure, so every pin is a plain level.

Top module: `gain_word_rx`

## Requirements
- R1: During and after reset the latched code is 0, the valid flag is 0 and transmit is disabled.
- R2: While the synchronized enable is low, each rising edge of the synchronized serial clock shifts the data bit into the low end of a 7-bit register. After an 8-bit word sent MSB first and committed, the latched code equals the word's low 7 bits.
- R3: Serial-clock edges that arrive while the enable is high leave the shift register unchanged. A commit that follows with no clocks in between latches the earlier contents.
- R4: The latch changes only on a rising enable edge, which copies the shift register into it. Falling enable edges and shifting leave the latched code as it was.
- R5: The valid flag is set by the first commit and stays set until reset.
- R6: The coarse index is min(code[6:3], 8) and the fine index is code[2:0].
- R7: The gain step is coarse*8 + fine. It equals the code for codes 0 to 71 and equals 64 + code[2:0] for codes 72 to 127.
- R8: Bit 7 of the word is ignored: words w and w+128 give identical outputs.
- R9: The mode output is combinational from the pins and the valid flag, with this priority: sleep_n low gives 2'b10; otherwise pd_n low gives 2'b01; otherwise valid clear gives 2'b11; otherwise 2'b00 (transmit).
- R10: tx_en_o is 1 exactly when the mode is 2'b00.
- R11: A rising enable edge at the pin changes the latched outputs on the third core-clock edge after it (SYNC_STAGES+1 edges), and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock; bits are taken on its rising edge |
| ser_en_n_i | input | 1 | Active-low enable: low allows shifting, rising edge commits the word |
| ser_data_i | input | 1 | Serial data, MSB first |
| pd_n_i | input | 1 | Asynchronous active-low power-down (gap between bursts) |
| sleep_n_i | input | 1 | Asynchronous active-low sleep |
| gain_code_o | output | 7 | Latched gain code |
| coarse_idx_o | output | 4 | Saturated coarse attenuation index |
| fine_idx_o | output | 3 | Fine vernier index |
| gain_step_o | output | 7 | Effective gain step, coarse*8+fine |
| gain_valid_o | output | 1 | A word has been committed since reset |
| tx_en_o | output | 1 | Transmit enable |
| pwr_mode_o | output | 2 | Power mode: 00 transmit, 01 burst gap, 10 sleep, 11 waiting for gain |

## Verification
Serial pins go through a two-flop synchronizer and one edge-detect register. A commit at the pin therefore reaches the latch, the decoded indices and the valid flag on the third core edge. Mode and transmit-enable follow the power pins at once, with no clock. The reference model keeps its own three-edge history of the pins and applies the shift and commit rules at that depth, and it is compared a quarter period after every rising edge. Directed checks sample the latch two edges after a commit to see the old code and one edge later to see the new one, and they probe the power pins one nanosecond after driving them.

// File: rtl/gwr_pkg.sv
`timescale 1ns/1ps
package gwr_pkg;
  typedef enum logic [1:0] {
    PM_XMIT  = 2'b00,
    PM_GAP   = 2'b01,
    PM_SLEEP = 2'b10,
    PM_HOLD  = 2'b11
  } pwr_mode_e;
endpackage

// File: rtl/gwr_sync.sv
`timescale 1ns/1ps
module gwr_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[g] <= RST_VAL;
        else        chain[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[g] <= RST_VAL;
        else        chain[g] <= chain[g-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/gwr_frontend.sv
`timescale 1ns/1ps
module gwr_frontend #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk_i,
  input  logic ser_en_n_i,
  input  logic ser_data_i,
  output logic shift_pulse_o,
  output logic load_pulse_o,
  output logic en_lvl_o,
  output logic data_bit_o
);
  // bit 2 data, bit 1 enable (idles high), bit 0 serial clock
  logic [2:0] sy;
  logic       clk_prev, en_prev;

  gwr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({ser_data_i, ser_en_n_i, ser_clk_i}),
    .q_o   (sy)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clk_prev <= 1'b0;
      en_prev  <= 1'b1;
    end else begin
      clk_prev <= sy[0];
      en_prev  <= sy[1];
    end

  assign en_lvl_o      = sy[1];
  assign data_bit_o    = sy[2];
  assign shift_pulse_o = sy[0] & ~clk_prev & ~sy[1];
  assign load_pulse_o  = sy[1] & ~en_prev;
endmodule

// File: rtl/gwr_shift.sv
`timescale 1ns/1ps
module gwr_shift #(
  parameter int STORE_BITS = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  shift_pulse_i,
  input  logic                  load_pulse_i,
  input  logic                  en_lvl_i,
  input  logic                  data_bit_i,
  output logic [STORE_BITS-1:0] code_o,
  output logic                  valid_o
);
  logic [STORE_BITS-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             shreg <= '0;
    else if (shift_pulse_i) shreg <= {shreg[STORE_BITS-2:0], data_bit_i};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      code_o  <= '0;
      valid_o <= 1'b0;
    end else if (load_pulse_i) begin
      code_o  <= shreg;
      valid_o <= 1'b1;
    end

  // R3: enable high freezes the shift register
  p_shift_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en_lvl_i |=> $stable(shreg));
  // R4: latch moves only on a commit pulse
  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_pulse_i |=> $stable(code_o));
  // R4: a commit copies the shift register
  p_latch_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse_i |=> (code_o == $past(shreg)));
  // R5: valid is sticky and set by a commit
  p_valid_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> valid_o);
  p_valid_on_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse_i |=> valid_o);
endmodule

// File: rtl/gwr_decode.sv
`timescale 1ns/1ps
module gwr_decode #(
  parameter int STORE_BITS = 7,
  parameter int FINE_BITS  = 3,
  parameter int COARSE_MAX = 8
) (
  input  logic [STORE_BITS-1:0]           code_i,
  output logic [STORE_BITS-FINE_BITS-1:0] coarse_o,
  output logic [FINE_BITS-1:0]            fine_o,
  output logic [STORE_BITS-1:0]           step_o
);
  localparam int CW        = STORE_BITS - FINE_BITS;
  localparam int VALID_TOP = COARSE_MAX * (1 << FINE_BITS) + (1 << FINE_BITS) - 1;
  localparam logic [CW-1:0] CMAX = CW'(COARSE_MAX);

  logic [CW-1:0] raw;

  always_comb begin
    raw      = code_i[STORE_BITS-1:FINE_BITS];
    coarse_o = (raw > CMAX) ? CMAX : raw;
    fine_o   = code_i[FINE_BITS-1:0];
    step_o   = {coarse_o, fine_o};
  end

  always_comb begin
    // R6: coarse index never exceeds its cap
    a_coarse_cap_r6: assert (coarse_o <= CMAX);
    // R7: inside the valid range the step equals the code
    if (int'(code_i) <= VALID_TOP) begin
      a_step_valid_r7: assert (step_o == code_i);
    end
  end
endmodule

// File: rtl/gwr_mode.sv
`timescale 1ns/1ps
module gwr_mode
  import gwr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pd_n_i,
  input  logic      sleep_n_i,
  input  logic      valid_i,
  output pwr_mode_e mode_o,
  output logic      tx_en_o
);
  always_comb begin
    if (!sleep_n_i)    mode_o = PM_SLEEP;
    else if (!pd_n_i)  mode_o = PM_GAP;
    else if (!valid_i) mode_o = PM_HOLD;
    else               mode_o = PM_XMIT;
  end

  assign tx_en_o = (mode_o == PM_XMIT);

  // R10: transmit needs a loaded gain and both power pins released
  p_tx_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en_o |-> (valid_i && pd_n_i && sleep_n_i));
  // R9: sleep wins over everything
  p_sleep_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n_i |-> (mode_o == PM_SLEEP));
endmodule

// File: rtl/gain_word_rx.sv
`timescale 1ns/1ps
module gain_word_rx #(
  parameter int STORE_BITS  = 7,
  parameter int FINE_BITS   = 3,
  parameter int COARSE_MAX  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            ser_clk_i,
  input  logic                            ser_en_n_i,
  input  logic                            ser_data_i,
  input  logic                            pd_n_i,
  input  logic                            sleep_n_i,
  output logic [STORE_BITS-1:0]           gain_code_o,
  output logic [STORE_BITS-FINE_BITS-1:0] coarse_idx_o,
  output logic [FINE_BITS-1:0]            fine_idx_o,
  output logic [STORE_BITS-1:0]           gain_step_o,
  output logic                            gain_valid_o,
  output logic                            tx_en_o,
  output logic [1:0]                      pwr_mode_o
);
  import gwr_pkg::*;

  logic      shift_pulse, load_pulse, en_lvl, data_bit;
  pwr_mode_e mode;

  gwr_frontend #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk           (clk),
    .rst_n         (rst_n),
    .ser_clk_i     (ser_clk_i),
    .ser_en_n_i    (ser_en_n_i),
    .ser_data_i    (ser_data_i),
    .shift_pulse_o (shift_pulse),
    .load_pulse_o  (load_pulse),
    .en_lvl_o      (en_lvl),
    .data_bit_o    (data_bit)
  );

  gwr_shift #(.STORE_BITS(STORE_BITS)) u_shift (
    .clk           (clk),
    .rst_n         (rst_n),
    .shift_pulse_i (shift_pulse),
    .load_pulse_i  (load_pulse),
    .en_lvl_i      (en_lvl),
    .data_bit_i    (data_bit),
    .code_o        (gain_code_o),
    .valid_o       (gain_valid_o)
  );

  gwr_decode #(
    .STORE_BITS (STORE_BITS),
    .FINE_BITS  (FINE_BITS),
    .COARSE_MAX (COARSE_MAX)
  ) u_dec (
    .code_i   (gain_code_o),
    .coarse_o (coarse_idx_o),
    .fine_o   (fine_idx_o),
    .step_o   (gain_step_o)
  );

  gwr_mode u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .pd_n_i    (pd_n_i),
    .sleep_n_i (sleep_n_i),
    .valid_i   (gain_valid_o),
    .mode_o    (mode),
    .tx_en_o   (tx_en_o)
  );

  assign pwr_mode_o = mode;

  // R1: nothing transmits before the first commit
  p_no_tx_before_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !gain_valid_o |-> !tx_en_o);
  // R3: shift and commit never coincide
  p_pulse_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({shift_pulse, load_pulse}));
endmodule

// File: tb/gain_word_rx_tb.sv
`timescale 1ns/1ps
module gain_word_rx_tb;
  localparam int SYN = 2;
  localparam int H   = 4;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       s_clk = 1'b0, s_en_n = 1'b1, s_data = 1'b0;
  logic       pd_n = 1'b0, sleep_n = 1'b1;
  logic [6:0] code, step;
  logic [3:0] coarse;
  logic [2:0] fine;
  logic       valid, tx_en;
  logic [1:0] mode;

  int  checks = 0, fails = 0;
  bit  done = 0;

  always #2.5 clk = ~clk;

  gain_word_rx u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(s_clk), .ser_en_n_i(s_en_n),
    .ser_data_i(s_data), .pd_n_i(pd_n), .sleep_n_i(sleep_n),
    .gain_code_o(code), .coarse_idx_o(coarse), .fine_idx_o(fine),
    .gain_step_o(step), .gain_valid_o(valid), .tx_en_o(tx_en), .pwr_mode_o(mode)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_coarse(int c);
    int r = c / 8;
    return (r > 8) ? 8 : r;
  endfunction

  function automatic int exp_mode(bit sl_n, bit p_n, bit v);
    if (!sl_n) return 2;
    if (!p_n)  return 1;
    if (!v)    return 3;
    return 0;
  endfunction

  // behavioural reference: pin history, rules applied SYN edges late
  bit hc[$], he[$], hd[$];
  int m_sh = 0, m_code = 0;
  bit m_valid = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      hc = {0, 0, 0, 0}; he = {1, 1, 1, 1}; hd = {0, 0, 0, 0};
      m_sh = 0; m_code = 0; m_valid = 0;
    end else begin
      hc.push_front(s_clk);  void'(hc.pop_back());
      he.push_front(s_en_n); void'(he.pop_back());
      hd.push_front(s_data); void'(hd.pop_back());
      if (hc[SYN] && !hc[SYN+1] && !he[SYN]) m_sh = (m_sh * 2 + int'(hd[SYN])) % 128;
      if (he[SYN] && !he[SYN+1]) begin m_code = m_sh; m_valid = 1; end
      #1.25;
      chk("R4 code", int'(code), m_code);
      chk("R6 coarse", int'(coarse), exp_coarse(m_code));
      chk("R6 fine", int'(fine), m_code % 8);
      chk("R7 step", int'(step), exp_coarse(m_code) * 8 + m_code % 8);
      chk("R5 valid", int'(valid), int'(m_valid));
      chk("R9 mode", int'(mode), exp_mode(sleep_n, pd_n, m_valid));
      chk("R10 tx", int'(tx_en), int'(exp_mode(sleep_n, pd_n, m_valid) == 0));
    end
  end

  task automatic shift_bits(int w);
    @(negedge clk) s_en_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      s_data = w[i];
      repeat (H) @(negedge clk);
      s_clk = 1'b1;
      repeat (H) @(negedge clk);
      s_clk = 1'b0;
    end
    repeat (H) @(negedge clk);
  endtask

  task automatic commit();
    s_en_n = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  initial begin
    int prev_step;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 code", int'(code), 0);
    chk("R1 valid", int'(valid), 0);
    chk("R1 tx", int'(tx_en), 0);
    rst_n = 1'b1;
    @(negedge clk) pd_n = 1'b1;
    #1;
    chk("R9 hold before load", int'(mode), 3);
    chk("R1 tx before load", int'(tx_en), 0);

    // R2, R6, R7, R8: every word value
    for (int w = 0; w < 256; w++) begin
      shift_bits(w);
      commit();
      chk("R2 code", int'(code), w % 128);
      chk("R6 coarse", int'(coarse), (w % 128 > 71) ? 8 : (w % 128) / 8);
      chk("R7 step", int'(step), (w % 128 <= 71) ? w % 128 : 64 + w % 8);
      if (w < 128) prev_step = int'(step);
      if (w == 127 + 1) chk("R8 wrap", int'(step), 0);
      if (w >= 128) chk("R8 top bit ignored", int'(code), w - 128);
    end
    chk("R5 valid sticky", int'(valid), 1);
    chk("R10 tx on", int'(tx_en), 1);

    // R3: clocks with enable high are ignored
    shift_bits(8'h35);
    commit();
    s_data = 1'b1;
    for (int k = 0; k < 3; k++) begin
      s_clk = 1'b1; repeat (H) @(negedge clk);
      s_clk = 1'b0; repeat (H) @(negedge clk);
    end
    s_en_n = 1'b0; repeat (H) @(negedge clk);
    commit();
    chk("R3 no shift while high", int'(code), 8'h35);

    // R4 hold during shifting, R11 latency
    shift_bits(8'h10); commit();
    shift_bits(8'h2A);
    chk("R4 hold while shifting", int'(code), 8'h10);
    s_en_n = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk("R11 not yet after two edges", int'(code), 8'h10);
    @(posedge clk); #1;
    chk("R11 due on third edge", int'(code), 8'h2A);
    repeat (H) @(negedge clk);

    // R9, R10 power pin priority, no clock needed
    sleep_n = 1'b0; pd_n = 1'b0; #1;
    chk("R9 sleep over gap", int'(mode), 2);
    pd_n = 1'b1; #1;
    chk("R9 sleep", int'(mode), 2);
    chk("R10 tx off in sleep", int'(tx_en), 0);
    sleep_n = 1'b1; pd_n = 1'b0; #1;
    chk("R9 gap", int'(mode), 1);
    chk("R10 tx off in gap", int'(tx_en), 0);
    pd_n = 1'b1; #1;
    chk("R9 transmit", int'(mode), 0);
    chk("R10 tx on", int'(tx_en), 1);
    repeat (4) @(negedge clk);

    // R1 again: reset clears the latch and valid
    rst_n = 1'b0; #1;
    chk("R1 code cleared", int'(code), 0);
    chk("R1 valid cleared", int'(valid), 0);
    chk("R10 tx off after reset", int'(tx_en), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule